// File: doc/BRIEF.md
# Two-Channel DC-Blocking Filter with Offset Hold

This block removes the DC component from two interleaved streams of signed 24-bit audio samples. For each channel it keeps a running estimate of the offset in a leaky integrator and subtracts that estimate from every sample that passes. One sample enters per cycle, tagged with its channel number, and the filtered result leaves one cycle later with the same tag.

A per-channel hold input stops the offset estimate from learning while the held value is still subtracted. A system calibration therefore runs the filter until the estimate has settled and then raises hold, which keeps the learned offset as a fixed correction. A strap input selects the operating style. With the strap high the filter is forced on. With the strap low a per-channel enable decides between filtering and passing samples through untouched.

Top module: `dcb_pair`

## Requirements
- R1: A synchronous reset (rst_ni low at a clock edge) clears both offset accumulators to zero and drives m_valid_o low. The first filtered sample after reset therefore comes out equal to its input.
- R2: Every cycle with s_valid_i high produces exactly one output on the next cycle: m_valid_o high, and m_chan_o equal to the s_chan_i of that sample. A cycle with s_valid_i low gives m_valid_o low on the next cycle.
- R3: In tracking mode (active, hold low) the selected channel's accumulator A, a signed value with 8 fractional bits, becomes A + floor((x*256 − A) / 2^K_SHIFT) after a sample x.
- R4: When a channel is active, the output is x − floor(A / 256), where A is that channel's accumulator before this sample's update.
- R5: The subtraction saturates: a result above 8388607 comes out as 8388607, and a result below −8388608 comes out as −8388608. It never wraps.
- R6: While a channel is active and its frz_i bit is high, its accumulator keeps its value and the held offset is still subtracted as in R4.
- R7: When frz_i falls, learning resumes from the held accumulator value with no reinitialisation.
- R8: With hw_mode_i low and a channel's en_i bit low, that channel's output equals its input bit for bit, and its accumulator keeps its value, so filtering continues from that value when it is enabled again.
- R9: With hw_mode_i high a channel filters as in R3 and R4 whatever the value of its en_i bit.
- R10: A sample on one channel leaves the accumulator of the other channel unchanged, and a cycle without a valid sample changes no accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| hw_mode_i | input | 1 | Strap: 1 forces the filter on for both channels |
| en_i | input | 2 | Per-channel filter enable, used when the strap is 0 |
| frz_i | input | 2 | Per-channel hold of the offset estimate |
| s_valid_i | input | 1 | Input sample strobe |
| s_chan_i | input | 1 | Channel number of the input sample |
| s_data_i | input | 24 | Input sample, two's complement |
| m_valid_o | output | 1 | Output sample strobe |
| m_chan_o | output | 1 | Channel number of the output sample |
| m_data_o | output | 24 | Filtered sample, two's complement |

## Verification
The bench builds the block with K_SHIFT set to 4 and all other parameters at their defaults. With that setting the estimate settles within a few dozen samples instead of thousands. A run well within the cycle budget can then drive a channel to a settled full-scale offset, hit both saturation limits with an opposite full-scale step, and see a held offset diverge from a learning one. The 24-bit width and the 8 fractional bits keep their defaults, so the saturation boundaries are the real ±2^23 limits.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    // Per-channel operating mode, derived from strap, enable and hold
    typedef enum logic [1:0] {
        MD_PASS  = 2'd0,   // samples pass untouched, estimate kept
        MD_TRACK = 2'd1,   // estimate learns, offset subtracted
        MD_HOLD  = 2'd2    // estimate frozen, offset still subtracted
    } dcb_mode_e;

endpackage

// File: rtl/dcb_mode_dec.sv
module dcb_mode_dec
    import dcb_pkg::*;
(
    input  logic      hw_mode_i,
    input  logic      en_i,
    input  logic      frz_i,
    output dcb_mode_e mode_o
);

    logic active;

    always_comb begin
        active = hw_mode_i | en_i;
        if (!active) begin
            mode_o = MD_PASS;
        end else if (frz_i) begin
            mode_o = MD_HOLD;
        end else begin
            mode_o = MD_TRACK;
        end
    end

endmodule

// File: rtl/dcb_leak_step.sv
module dcb_leak_step #(
    parameter int DW      = 24,
    parameter int FRAC    = 8,
    parameter int K_SHIFT = 10,
    localparam int AW     = DW + FRAC
) (
    input  logic [DW-1:0] x_i,
    input  logic [AW-1:0] acc_i,
    output logic [AW-1:0] acc_o
);

    logic signed [AW:0] x_ext;
    logic signed [AW:0] acc_ext;
    logic signed [AW:0] diff;

    always_comb begin
        x_ext   = $signed({x_i[DW-1], x_i, {FRAC{1'b0}}});
        acc_ext = $signed({acc_i[AW-1], acc_i});
        diff    = x_ext - acc_ext;
        // the result lies between acc and x_ext, so it fits in AW bits
        acc_o   = AW'(acc_ext + (diff >>> K_SHIFT));
    end

endmodule

// File: rtl/dcb_sat_sub.sv
module dcb_sat_sub #(
    parameter int DW = 24
) (
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] ofs_i,
    output logic [DW-1:0] y_o
);

    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] wide;

    always_comb begin
        wide = {x_i[DW-1], x_i} - {ofs_i[DW-1], ofs_i};
        if (wide[DW] != wide[DW-1]) begin
            y_o = wide[DW] ? NEG_LIM : POS_LIM;
        end else begin
            y_o = wide[DW-1:0];
        end
    end

endmodule

// File: rtl/dcb_pair.sv
module dcb_pair
    import dcb_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int DW      = 24,
    parameter int FRAC    = 8,
    parameter int K_SHIFT = 10,
    localparam int AW     = DW + FRAC,
    localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           hw_mode_i,
    input  logic [NCH-1:0] en_i,
    input  logic [NCH-1:0] frz_i,
    input  logic           s_valid_i,
    input  logic [CW-1:0]  s_chan_i,
    input  logic [DW-1:0]  s_data_i,
    output logic           m_valid_o,
    output logic [CW-1:0]  m_chan_o,
    output logic [DW-1:0]  m_data_o
);

    typedef struct packed {
        logic [NCH-1:0][AW-1:0] acc;
        logic                   vld;
        logic [CW-1:0]          chan;
        logic [DW-1:0]          data;
    } dcb_state_t;

    dcb_state_t st_d, st_q;

    dcb_mode_e mode_w [NCH];
    dcb_mode_e mode_sel;

    logic [AW-1:0]        acc_sel;
    logic [AW-1:0]        acc_nxt;
    logic [DW-1:0]        y_sub;
    logic [NCH*AW-1:0]    acc_vec;

    // one mode decoder per channel
    for (genvar g = 0; g < NCH; g++) begin : g_mode
        dcb_mode_dec u_dec (
            .hw_mode_i (hw_mode_i),
            .en_i      (en_i[g]),
            .frz_i     (frz_i[g]),
            .mode_o    (mode_w[g])
        );
    end

    assign mode_sel = mode_w[s_chan_i];
    assign acc_sel  = st_q.acc[s_chan_i];
    assign acc_vec  = st_q.acc;

    // one arithmetic path, shared by the channels in time
    dcb_leak_step #(
        .DW      (DW),
        .FRAC    (FRAC),
        .K_SHIFT (K_SHIFT)
    ) u_step (
        .x_i   (s_data_i),
        .acc_i (acc_sel),
        .acc_o (acc_nxt)
    );

    dcb_sat_sub #(
        .DW (DW)
    ) u_sub (
        .x_i   (s_data_i),
        .ofs_i (acc_sel[AW-1:FRAC]),
        .y_o   (y_sub)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = s_valid_i;
        if (s_valid_i) begin
            st_d.chan = s_chan_i;
            unique case (mode_sel)
                MD_TRACK: begin
                    st_d.data          = y_sub;
                    st_d.acc[s_chan_i] = acc_nxt;
                end
                MD_HOLD: begin
                    st_d.data = y_sub;
                end
                default: begin
                    st_d.data = s_data_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_valid_o = st_q.vld;
    assign m_chan_o  = st_q.chan;
    assign m_data_o  = st_q.data;

endmodule

// File: rtl/dcb_pair_chk.sv
module dcb_pair_chk #(
    parameter int NCH = 2,
    parameter int DW  = 24,
    parameter int AW  = 32,
    parameter int CW  = 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              hw_mode_i,
    input logic [NCH-1:0]    en_i,
    input logic [NCH-1:0]    frz_i,
    input logic              s_valid_i,
    input logic [CW-1:0]     s_chan_i,
    input logic [DW-1:0]     s_data_i,
    input logic              m_valid_o,
    input logic [CW-1:0]     m_chan_o,
    input logic [DW-1:0]     m_data_o,
    input logic [NCH*AW-1:0] acc_vec
);

    // R1: nothing comes out in the cycle right after reset is released
    a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !m_valid_o);

    // R2: each accepted sample gives one output a cycle later
    a_r2_out_follows_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_valid_i |=> m_valid_o);

    a_r2_no_spurious_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_valid_i |=> !m_valid_o);

    a_r2_chan_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_valid_i |=> (m_chan_o == $past(s_chan_i)));

    // R8: a disabled channel passes the sample unchanged
    a_r8_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_valid_i && !hw_mode_i && !en_i[s_chan_i]) |=> (m_data_o == $past(s_data_i)));

    // R8: a disabled channel keeps its estimate
    a_r8_pass_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_valid_i && !hw_mode_i && !en_i[s_chan_i]) |=> $stable(acc_vec));

    // R6: hold stops learning
    a_r6_hold_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_valid_i && (hw_mode_i || en_i[s_chan_i]) && frz_i[s_chan_i]) |=> $stable(acc_vec));

    // R10: an idle cycle touches no estimate
    a_r10_idle_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_valid_i |=> $stable(acc_vec));

endmodule

bind dcb_pair dcb_pair_chk #(
    .NCH (NCH),
    .DW  (DW),
    .AW  (AW),
    .CW  (CW)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_mode_i (hw_mode_i),
    .en_i      (en_i),
    .frz_i     (frz_i),
    .s_valid_i (s_valid_i),
    .s_chan_i  (s_chan_i),
    .s_data_i  (s_data_i),
    .m_valid_o (m_valid_o),
    .m_chan_o  (m_chan_o),
    .m_data_o  (m_data_o),
    .acc_vec   (acc_vec)
);

// File: tb/dcb_pair_bench.sv
`timescale 1ns/1ps
module dcb_pair_bench;

    localparam int KS = 4;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        hw_mode_i = 1'b0;
    logic [1:0]  en_i = 2'b00;
    logic [1:0]  frz_i = 2'b00;
    logic        s_valid_i = 1'b0;
    logic [0:0]  s_chan_i = 1'b0;
    logic [23:0] s_data_i = '0;
    logic        m_valid_o;
    logic [0:0]  m_chan_o;
    logic [23:0] m_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    longint acc_m [2];

    int    q_data [$];
    int    q_chan [$];
    string q_tag  [$];

    always #4 clk_i = ~clk_i;

    dcb_pair #(.K_SHIFT(KS)) u_dcb_pair (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hw_mode_i (hw_mode_i),
        .en_i      (en_i),
        .frz_i     (frz_i),
        .s_valid_i (s_valid_i),
        .s_chan_i  (s_chan_i),
        .s_data_i  (s_data_i),
        .m_valid_o (m_valid_o),
        .m_chan_o  (m_chan_o),
        .m_data_o  (m_data_o)
    );

    task automatic check(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: presents one sample and queues the expected result
    task automatic send(int ch, int x, string tag);
        longint ofs, y, diff;
        bit active;
        @(negedge clk_i);
        s_valid_i = 1'b1;
        s_chan_i  = ch[0:0];
        s_data_i  = x[23:0];
        active = hw_mode_i || en_i[ch];
        if (!active) begin
            y = x;
        end else begin
            ofs = acc_m[ch] >>> 8;
            y = longint'(x) - ofs;
            if (y > 8388607) y = 8388607;
            if (y < -8388608) y = -8388608;
            if (!frz_i[ch]) begin
                diff = longint'(x) * 256 - acc_m[ch];
                acc_m[ch] = acc_m[ch] + (diff >>> KS);
            end
        end
        q_data.push_back(int'(y));
        q_chan.push_back(ch);
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            s_valid_i = 1'b0;
        end
    endtask

    task automatic set_ctl(bit hw, logic [1:0] en, logic [1:0] frz);
        @(negedge clk_i);
        s_valid_i = 1'b0;
        hw_mode_i = hw;
        en_i      = en;
        frz_i     = frz;
    endtask

    // monitor: pops and compares each result as it appears
    always @(negedge clk_i) begin
        if (rst_ni && m_valid_o) begin
            if (q_data.size() == 0) begin
                check("R2 spurious output", 1, 0);
            end else begin
                string t;
                int ed, ec;
                ed = q_data.pop_front();
                ec = q_chan.pop_front();
                t  = q_tag.pop_front();
                check({t, " data"}, longint'($signed(m_data_o)), longint'(ed));
                check("R2 channel tag", longint'(m_chan_o), longint'(ec));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        acc_m[0] = 0;
        acc_m[1] = 0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1: reset state at the outputs
        check("R1 m_valid after reset", longint'(m_valid_o), 0);
        check("R1 m_data after reset", longint'($signed(m_data_o)), 0);

        set_ctl(1'b0, 2'b11, 2'b00);
        send(0, 1000, "R1 first sample passes at zero offset");
        send(1, -777, "R1 first sample ch1");
        idle(2);

        // R3 R4 R10: both channels learn different offsets, interleaved
        for (int i = 0; i < 80; i++) begin
            send(0, 5000 + (i % 3), "R3 track ch0");
            send(1, -3000, "R10 track ch1 interleaved");
        end
        // R2: gaps between samples
        for (int i = 0; i < 10; i++) begin
            send(0, 5000, "R4 settled ch0");
            idle(i % 3);
        end

        // R6: hold ch0, changed input sees the held offset
        set_ctl(1'b0, 2'b11, 2'b01);
        for (int i = 0; i < 20; i++) send(0, 12000 - 100 * i, "R6 hold ch0");
        send(1, 4000, "R10 ch1 learns while ch0 held");
        send(0, 12000, "R6 held offset unchanged");

        // R7: release and resume from held value
        set_ctl(1'b0, 2'b11, 2'b00);
        for (int i = 0; i < 30; i++) send(0, 20000, "R7 resume from held");

        // R8: disable ch1, pass-through and kept estimate
        set_ctl(1'b0, 2'b01, 2'b00);
        send(1, 123456, "R8 pass-through");
        send(1, -8388608, "R8 pass-through negative limit");
        send(1, 8388607, "R8 pass-through positive limit");
        set_ctl(1'b0, 2'b11, 2'b00);
        send(1, -3000, "R8 estimate kept across disable");

        // R9: strap forces filtering with enables low
        set_ctl(1'b1, 2'b00, 2'b00);
        for (int i = 0; i < 20; i++) send(1, 7000, "R9 strap forces filter");

        // R5: saturation at both limits
        set_ctl(1'b0, 2'b11, 2'b00);
        for (int i = 0; i < 150; i++) begin
            send(0, 8388607, "R5 settle ch0 high");
            send(1, -8388608, "R5 settle ch1 low");
        end
        send(0, -8388608, "R5 negative saturation");
        send(1, 8388607, "R5 positive saturation");
        idle(4);

        // R2: every queued result was produced
        check("R2 outstanding results", longint'(q_data.size()), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule